// File: doc/BRIEF.md
# Pipelined Bus Cycle Controller

This block turns requests from an internal queue into bus cycles on an external burst bus. The queue shows one request at a time with its address, direction, memory or I/O space, and a locked flag and a writeback flag. When the block starts a cycle it raises the address strobe for one clock. In that same clock it drives the address, the direction and the memory/I/O qualifier, and it takes the request from the queue.

A memory read can end in one of two ways. The block samples the cache-enable input once, in the first clock after the strobe where next-address or burst-ready is high. If cache-enable is high there, the read becomes a line fill of four transfers. If it is low, the read ends on the first burst-ready. Writes and I/O cycles always take a single transfer. When memory raises next-address and another request is waiting, the block can issue a second, pipelined cycle while the first is still running. This is never done for a locked or writeback cycle, on either side. At most two cycles are in flight at once.

Top module: `bcc_bus_ctrl`

## Requirements
- R1: After reset the block is idle: address strobe, data-valid, cycle-done and fill-done are all low, and no burst-ready has any effect.
- R2: With no cycle in progress, a pending request raises the address strobe for one clock. The address, direction and memory/I/O qualifier (1 = memory, 0 = I/O) are valid in that same clock, and the request is taken.
- R3: Cache-enable is sampled only in the first clock after the strobe in which next-address or burst-ready is high. Its value in any later clock of that cycle has no effect.
- R4: A memory read that samples cache-enable high becomes a line fill. Data-valid is high on each of its four burst-ready clocks. Fill-done and cycle-done are high together on the fourth.
- R5: A memory read that samples cache-enable low ends on its first burst-ready, with data-valid and cycle-done high and fill-done low.
- R6: Writes and I/O reads end on their first burst-ready whatever cache-enable shows, and never raise fill-done. Data-valid is low for writes.
- R7: While a cycle is running, once next-address has been high in that cycle and a request is pending, the block issues a pipelined address strobe for that request.
- R8: No pipelined strobe is issued when no request is pending, when the current cycle is locked or a writeback, or when the pending request is locked or a writeback. Such a request waits until the bus is idle.
- R9: At most two cycles are outstanding. A third request gets no strobe while two are in flight, even with next-address high.
- R10: When the first cycle completes, the pipelined cycle becomes current and samples its own cache-enable at its own first next-address or burst-ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | A request is pending in the queue |
| req_addr | input | 32 | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory, 0 = I/O |
| req_lock | input | 1 | Request is a locked cycle |
| req_wb | input | 1 | Request is a writeback cycle |
| brdy | input | 1 | Burst-ready from memory |
| nxt_addr | input | 1 | Next-address hint from memory |
| cache_en | input | 1 | Cache-enable from memory |
| ads | output | 1 | Address strobe; also pops the request |
| bus_addr | output | 32 | Address, valid with the strobe |
| bus_mio | output | 1 | Memory/I/O qualifier, valid with the strobe |
| bus_write | output | 1 | Direction, valid with the strobe |
| data_valid | output | 1 | Read data valid on this burst-ready |
| cycle_done | output | 1 | The current cycle ends in this clock |
| fill_done | output | 1 | A line fill ends in this clock |

## Verification
The hardest state to reach is a full pipeline that then hands over. A line fill must be current and a pipelined cycle already issued when a third request arrives and next-address stays high. The stimulus sets this up by raising next-address with a second request pending in the clock after the first strobe, then keeping a third request and next-address high through all four fill beats. The second cycle must then become current and take its own cache-enable sample from next-address, with a contrary value on its burst-ready. Locked and writeback requests are brought in against a pending next-address to show that they wait for an idle bus.

// File: rtl/bcc_pkg.sv
package bcc_pkg;
  parameter int ADDR_W     = 32;
  parameter int FILL_BEATS = 4;
  localparam int CNT_W = (FILL_BEATS > 1) ? $clog2(FILL_BEATS) : 1;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              wr;
    logic              mem;
    logic              lock;
    logic              wb;
  } bcc_cyc_t;
endpackage

// File: rtl/bcc_beat_tracker.sv
module bcc_beat_tracker
  import bcc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cur_v,
  input  logic cur_rd_mem,
  input  logic brdy,
  input  logic nxt_addr,
  input  logic cache_en,
  output logic fill_now,
  output logic cur_done,
  output logic na_seen
);
  logic             sampled_q, sampled_d;
  logic             fill_q, fill_d;
  logic             na_q, na_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             samp_en;

  assign samp_en  = cur_v && !sampled_q && (nxt_addr || brdy);
  assign fill_now = sampled_q ? fill_q : (cur_rd_mem && cache_en);
  assign cur_done = cur_v && brdy &&
                    (!fill_now || (cnt_q == CNT_W'(FILL_BEATS-1)));
  assign na_seen  = na_q;

  always_comb begin
    sampled_d = sampled_q;
    fill_d    = fill_q;
    na_d      = na_q;
    cnt_d     = cnt_q;
    if (cur_done) begin
      sampled_d = 1'b0;
      fill_d    = 1'b0;
      na_d      = 1'b0;
      cnt_d     = '0;
    end else if (cur_v) begin
      if (samp_en) begin
        sampled_d = 1'b1;
        fill_d    = cur_rd_mem && cache_en;
      end
      if (brdy)     cnt_d = cnt_q + 1'b1;
      if (nxt_addr) na_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sampled_q <= 1'b0;
      fill_q    <= 1'b0;
      na_q      <= 1'b0;
      cnt_q     <= '0;
    end else begin
      sampled_q <= sampled_d;
      fill_q    <= fill_d;
      na_q      <= na_d;
      cnt_q     <= cnt_d;
    end
  end
endmodule

// File: rtl/bcc_issue_gate.sv
module bcc_issue_gate (
  input  logic req_valid,
  input  logic req_lock,
  input  logic req_wb,
  input  logic cur_v,
  input  logic cur_lock,
  input  logic cur_wb,
  input  logic pipe_v,
  input  logic cur_done,
  input  logic nxt_addr,
  input  logic na_seen,
  output logic issue_idle,
  output logic issue_pipe
);
  logic pipe_ok;

  assign pipe_ok    = !cur_lock && !cur_wb && !req_lock && !req_wb;
  assign issue_idle = req_valid && !cur_v;
  assign issue_pipe = req_valid && cur_v && !pipe_v && !cur_done &&
                      (nxt_addr || na_seen) && pipe_ok;
endmodule

// File: rtl/bcc_bus_ctrl.sv
module bcc_bus_ctrl
  import bcc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_mem,
  input  logic              req_lock,
  input  logic              req_wb,
  input  logic              brdy,
  input  logic              nxt_addr,
  input  logic              cache_en,
  output logic              ads,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_mio,
  output logic              bus_write,
  output logic              data_valid,
  output logic              cycle_done,
  output logic              fill_done
);
  bcc_cyc_t cur_q, cur_d, pipe_q, pipe_d, req_c;
  logic     cur_v_q, cur_v_d, pipe_v_q, pipe_v_d;
  logic     issue_idle, issue_pipe, cur_done, fill_now, na_seen;
  logic     cur_lock, cur_wb, cur_wr, cur_mem;

  assign req_c    = '{addr: req_addr, wr: req_write, mem: req_mem,
                      lock: req_lock, wb: req_wb};
  assign cur_lock = cur_q.lock;
  assign cur_wb   = cur_q.wb;
  assign cur_wr   = cur_q.wr;
  assign cur_mem  = cur_q.mem;

  bcc_beat_tracker u_trk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cur_v      (cur_v_q),
    .cur_rd_mem (!cur_wr && cur_mem),
    .brdy       (brdy),
    .nxt_addr   (nxt_addr),
    .cache_en   (cache_en),
    .fill_now   (fill_now),
    .cur_done   (cur_done),
    .na_seen    (na_seen)
  );

  bcc_issue_gate u_gate (
    .req_valid  (req_valid),
    .req_lock   (req_lock),
    .req_wb     (req_wb),
    .cur_v      (cur_v_q),
    .cur_lock   (cur_lock),
    .cur_wb     (cur_wb),
    .pipe_v     (pipe_v_q),
    .cur_done   (cur_done),
    .nxt_addr   (nxt_addr),
    .na_seen    (na_seen),
    .issue_idle (issue_idle),
    .issue_pipe (issue_pipe)
  );

  assign ads        = issue_idle || issue_pipe;
  assign bus_addr   = req_addr;
  assign bus_mio    = req_mem;
  assign bus_write  = req_write;
  assign data_valid = cur_v_q && brdy && !cur_wr;
  assign cycle_done = cur_done;
  assign fill_done  = cur_done && fill_now;

  always_comb begin
    cur_d    = cur_q;
    cur_v_d  = cur_v_q;
    pipe_d   = pipe_q;
    pipe_v_d = pipe_v_q;
    if (cur_done) begin
      cur_d    = pipe_q;
      cur_v_d  = pipe_v_q;
      pipe_v_d = 1'b0;
    end
    if (issue_idle) begin
      cur_d   = req_c;
      cur_v_d = 1'b1;
    end
    if (issue_pipe) begin
      pipe_d   = req_c;
      pipe_v_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q    <= '0;
      cur_v_q  <= 1'b0;
      pipe_q   <= '0;
      pipe_v_q <= 1'b0;
    end else begin
      cur_q    <= cur_d;
      cur_v_q  <= cur_v_d;
      pipe_q   <= pipe_d;
      pipe_v_q <= pipe_v_d;
    end
  end
endmodule

// File: rtl/bcc_checker.sv
module bcc_checker (
  input logic clk,
  input logic rst_n,
  input logic ads,
  input logic req_valid,
  input logic req_lock,
  input logic req_wb,
  input logic nxt_addr,
  input logic brdy,
  input logic data_valid,
  input logic cycle_done,
  input logic fill_done,
  input logic cur_v_q,
  input logic pipe_v_q,
  input logic cur_lock,
  input logic cur_wb,
  input logic cur_wr,
  input logic cur_mem,
  input logic na_seen
);
  // R2: a strobe only goes out for a pending request
  assert_ads_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ads |-> req_valid);

  // R9: no strobe while two cycles are in flight
  assert_two_outstanding_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ads |-> !(cur_v_q && pipe_v_q));

  // R8: pipelining is never used around locked or writeback cycles
  assert_no_pipe_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ads && cur_v_q) |-> (!cur_lock && !cur_wb && !req_lock && !req_wb));

  // R7: a pipelined strobe needs a next-address hint in the current cycle
  assert_pipe_needs_hint_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ads && cur_v_q) |-> (nxt_addr || na_seen));

  // R6: only memory reads can finish as a line fill
  assert_fill_is_mem_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |-> (cycle_done && !cur_wr && cur_mem));

  // R4: read data is only flagged on a burst-ready of a running cycle
  assert_dv_on_brdy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> (brdy && cur_v_q));
endmodule

bind bcc_bus_ctrl bcc_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ads        (ads),
  .req_valid  (req_valid),
  .req_lock   (req_lock),
  .req_wb     (req_wb),
  .nxt_addr   (nxt_addr),
  .brdy       (brdy),
  .data_valid (data_valid),
  .cycle_done (cycle_done),
  .fill_done  (fill_done),
  .cur_v_q    (cur_v_q),
  .pipe_v_q   (pipe_v_q),
  .cur_lock   (cur_lock),
  .cur_wb     (cur_wb),
  .cur_wr     (cur_wr),
  .cur_mem    (cur_mem),
  .na_seen    (na_seen)
);

// File: tb/tb_bcc_bus_ctrl.sv
module tb_bcc_bus_ctrl;
  logic        clk, rst_n;
  logic        req_valid, req_write, req_mem, req_lock, req_wb;
  logic [31:0] req_addr;
  logic        brdy, nxt_addr, cache_en;
  logic        ads, bus_mio, bus_write, data_valid, cycle_done, fill_done;
  logic [31:0] bus_addr;
  int          n_chk = 0, n_bad = 0;
  bit          finished = 0;

  bcc_bus_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_mem(req_mem), .req_lock(req_lock),
    .req_wb(req_wb), .brdy(brdy), .nxt_addr(nxt_addr), .cache_en(cache_en),
    .ads(ads), .bus_addr(bus_addr), .bus_mio(bus_mio), .bus_write(bus_write),
    .data_valid(data_valid), .cycle_done(cycle_done), .fill_done(fill_done)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic put_req(logic [31:0] a, logic w, logic m, logic l, logic b);
    req_valid = 1'b1; req_addr = a; req_write = w;
    req_mem = m; req_lock = l; req_wb = b;
  endtask

  task automatic bus(logic b, logic n, logic k);
    brdy = b; nxt_addr = n; cache_en = k;
  endtask

  task automatic t_reset();
    settle();
    chk("R1", "ads", ads, 0);
    chk("R1", "data_valid", data_valid, 0);
    bus(1, 0, 1); settle();
    chk("R1", "done on stray brdy", cycle_done, 0);
    chk("R1", "fill_done", fill_done, 0);
    bus(0, 0, 0);
  endtask

  task automatic t_fill();
    put_req(32'h1000_0040, 0, 1, 0, 0); settle();
    chk("R2", "ads", ads, 1);
    chk("R2", "addr", bus_addr, 32'h1000_0040);
    chk("R2", "mio", bus_mio, 1);
    chk("R2", "write", bus_write, 0);
    cyc(); req_valid = 0;
    bus(1, 0, 1); settle();
    chk("R4", "beat1 dv", data_valid, 1);
    chk("R4", "beat1 done", cycle_done, 0);
    for (int i = 2; i <= 3; i++) begin
      cyc(); bus(1, 0, 0); settle();
      chk("R3", "later ken ignored", cycle_done, 0);
    end
    cyc(); bus(1, 0, 0); settle();
    chk("R4", "beat4 fill_done", fill_done, 1);
    chk("R4", "beat4 cycle_done", cycle_done, 1);
    cyc(); settle();
    chk("R4", "no dv after fill", data_valid, 0);
    bus(0, 0, 0);
  endtask

  task automatic t_noncache();
    put_req(32'h2000_0000, 0, 1, 0, 0); settle();
    chk("R2", "ads", ads, 1);
    cyc(); req_valid = 0;
    bus(1, 0, 0); settle();
    chk("R5", "dv", data_valid, 1);
    chk("R5", "cycle_done", cycle_done, 1);
    chk("R5", "fill_done", fill_done, 0);
    cyc(); bus(1, 0, 1); settle();
    chk("R5", "ended after one beat", data_valid, 0);
    bus(0, 0, 0);
  endtask

  task automatic t_ken_at_na();
    put_req(32'h3000_0000, 0, 1, 0, 0); settle();
    cyc(); req_valid = 0;
    bus(0, 1, 1); settle();
    chk("R8", "na without pending", ads, 0);
    cyc(); bus(1, 0, 0); settle();
    chk("R3", "ken sampled at na", cycle_done, 0);
    chk("R3", "dv beat1", data_valid, 1);
    cyc(); bus(1, 0, 0); settle();
    cyc(); bus(1, 0, 0); settle();
    chk("R3", "beat3 not done", cycle_done, 0);
    cyc(); bus(1, 0, 0); settle();
    chk("R3", "fill done on beat4", fill_done, 1);
    cyc(); bus(0, 0, 0);
  endtask

  task automatic t_write_io();
    put_req(32'h4000_0000, 1, 1, 0, 0); settle();
    chk("R2", "write strobe dir", bus_write, 1);
    cyc(); req_valid = 0;
    bus(1, 0, 1); settle();
    chk("R6", "write done", cycle_done, 1);
    chk("R6", "write dv", data_valid, 0);
    chk("R6", "write fill", fill_done, 0);
    cyc(); bus(0, 0, 0);
    put_req(32'h0000_0080, 0, 0, 0, 0); settle();
    chk("R2", "io mio", bus_mio, 0);
    cyc(); req_valid = 0;
    bus(1, 0, 1); settle();
    chk("R6", "io done", cycle_done, 1);
    chk("R6", "io fill", fill_done, 0);
    chk("R6", "io dv", data_valid, 1);
    cyc(); bus(0, 0, 0);
  endtask

  task automatic t_pipe();
    put_req(32'h5000_0000, 0, 1, 0, 0); settle();
    cyc();
    put_req(32'h5000_1000, 0, 1, 0, 0);
    bus(0, 1, 1); settle();
    chk("R7", "pipelined ads", ads, 1);
    chk("R7", "pipelined addr", bus_addr, 32'h5000_1000);
    cyc();
    put_req(32'h5000_2000, 0, 1, 0, 0);
    for (int i = 1; i <= 4; i++) begin
      bus(1, 1, 0); settle();
      chk("R9", "third waits", ads, 0);
      if (i == 4) chk("R4", "first fill done", fill_done, 1);
      cyc();
    end
    bus(0, 0, 0); settle();
    chk("R10", "no hint yet", ads, 0);
    bus(0, 1, 0); settle();
    chk("R10", "third pipelined", ads, 1);
    chk("R10", "third addr", bus_addr, 32'h5000_2000);
    cyc(); req_valid = 0;
    bus(1, 0, 1); settle();
    chk("R10", "second single by na sample", cycle_done, 1);
    chk("R10", "second no fill", fill_done, 0);
    cyc(); bus(1, 0, 0); settle();
    chk("R10", "third done", cycle_done, 1);
    cyc(); bus(0, 0, 0);
  endtask

  task automatic t_lock_wb();
    put_req(32'h6000_0000, 0, 1, 1, 0); settle();
    chk("R2", "locked ads", ads, 1);
    cyc();
    put_req(32'h6000_1000, 0, 1, 0, 0);
    bus(0, 1, 0); settle();
    chk("R8", "no pipe behind lock", ads, 0);
    cyc(); bus(1, 0, 0); settle();
    chk("R8", "locked done", cycle_done, 1);
    chk("R8", "still no ads", ads, 0);
    cyc(); bus(0, 0, 0); settle();
    chk("R8", "issued when idle", ads, 1);
    cyc();
    put_req(32'h6000_2000, 1, 1, 0, 1);
    bus(0, 1, 0); settle();
    chk("R8", "writeback not pipelined", ads, 0);
    cyc(); bus(1, 0, 0); settle();
    chk("R8", "current done", cycle_done, 1);
    cyc(); bus(0, 0, 0); settle();
    chk("R8", "writeback issued idle", ads, 1);
    cyc(); req_valid = 0;
    bus(1, 0, 1); settle();
    chk("R6", "writeback single", cycle_done, 1);
    cyc(); bus(0, 0, 0);
  endtask

  initial begin
    #(4 * 20000);
    if (!finished) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 0; req_addr = '0; req_write = 0; req_mem = 0;
    req_lock = 0; req_wb = 0;
    bus(0, 0, 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cyc();
    t_reset();
    cyc();
    t_fill();
    t_noncache();
    t_ken_at_na();
    t_write_io();
    t_pipe();
    t_lock_wb();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule